// File: doc/BRIEF.md
# Interrupt Pin Service and Message Generator

This block sits between a set of interrupt request wires and a message write port. It keeps one pending bit per pin, and it scans the pins whose pending bit is set and whose mask is clear. Each pin it selects becomes one 32-bit address / 32-bit data write. The routing entries are held in a separate register block, one 64-bit entry per pin, and reach this block as a flat input vector. The register block owns the remote-request flag in each entry. This block asks the register block to set that flag with a one-cycle strobe per pin. The register block tells this block when it has cleared a flag, and when software has written the table, with two single-cycle pulses.

A level-mode pin is re-armed only when its remote-request flag is cleared. Repeated assertions of a level pin while the flag is set therefore fold into the request already delivered. An edge-mode pin drops its pending bit once it has been sent. An edge that arrives while the pin is masked is lost and is not stored. Request wire 0 is routed to pin 2, pin 0 has no request wire, and request wires numbered at or above the pin count have no effect.

The scanner is a three-state machine. IDLE waits for a pass request. SCAN looks at one pin per cycle in ascending order. SEND holds a message on the port until it is accepted. The transitions are:
- IDLE to SCAN on a start event, a table write or a flag clear, at pin 0.
- SCAN to SEND when the current pin produces a message.
- SCAN to SCAN on the next pin when the current pin is skipped.
- SEND to SCAN on the next pin when the port accepts the message.
- SCAN or SEND to SCAN at pin 0 after the last pin, if a new pass request arrived during the pass.
- SCAN or SEND to IDLE after the last pin otherwise.

Top module: `irq_msg_service`

## Requirements
- R1: After reset, msg_valid is low, rirr_set is all zero and no message is offered until a request arrives.
- R2: A rising request on wire 0 acts on pin 2 and not on pin 0. A request on a wire at or above NUM_PINS produces no message.
- R3: A level pin (entry bit 15 = 1) that is unmasked (entry bit 16 = 0), whose input is high and whose remote flag (entry bit 14) is clear, produces exactly one message and exactly one rirr_set pulse on that pin. rirr_set pulses only for level pins.
- R4: A level pin whose remote flag is already set gets an rirr_set pulse when a pass visits it, but no message is sent for it.
- R5: Driving a level input low clears its pending bit, so a later flag clear produces no message for it.
- R6: A rising edge on an unmasked edge pin (entry bit 15 = 0) produces exactly one message and no rirr_set pulse. A later pass sends nothing more for that pin.
- R7: A rising edge on a masked edge pin is discarded, and unmasking the pin afterwards sends nothing.
- R8: A masked level pin with a high input stays pending without being sent. Once a table write unmasks it, one message is sent. A masked pin never receives rirr_set.
- R9: Pins that are pending at the same time are sent in ascending pin order.
- R10: msg_addr = 0xFEE00000 | (entry[63:48] << 4) | (entry[11] << 2). msg_data = entry[7:0] | (entry[10:8] << 8) | (entry[15] << 15).
- R11: While msg_valid is high and msg_ready is low, msg_valid stays high and msg_addr and msg_data stay unchanged.
- R12: A pulse on rirr_clr starts a pass, so a level pin that is still high is sent again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | NUM_IN | Interrupt request wires |
| rte_flat | input | NUM_PINS*64 | Routing entries, pin p in bits [p*64 +: 64] |
| tbl_wr | input | 1 | One-cycle pulse: the routing table was written |
| rirr_clr | input | 1 | One-cycle pulse: a remote flag was cleared |
| rirr_set | output | NUM_PINS | One-cycle strobe per pin to set its remote flag |
| msg_valid | output | 1 | A message is offered |
| msg_ready | input | 1 | The message is accepted when this and msg_valid are high |
| msg_addr | output | 32 | Message address |
| msg_data | output | 32 | Message data |

## Verification
The assertions check the port handshake on every cycle. A held message must keep its address and data, and the address must carry the fixed base. They also check that at most one pin receives a flag strobe or a pending clear in any cycle, that only pending pins are cleared, that flag strobes go only to level pins, and that masked pins are never touched. Other behaviours depend on a sequence of inputs and table changes, and only the directed scenarios show them. These are the folding of level requests while the flag is set, the loss of masked edges, the wire-0 remap, the ascending send order, and the restart of a pass on a table write or a flag clear.

// File: rtl/irq_svc_pkg.sv
package irq_svc_pkg;

    localparam int RTE_W     = 64;
    localparam int VEC_LO    = 0;
    localparam int DLV_LO    = 8;
    localparam int DMODE_BIT = 11;
    localparam int RFLAG_BIT = 14;
    localparam int TRIG_BIT  = 15;
    localparam int MASK_BIT  = 16;
    localparam int DEST_LO   = 48;

    localparam logic [31:0] MSG_BASE = 32'hFEE0_0000;
    localparam int ADDR_DEST_SH  = 4;
    localparam int ADDR_DMODE_SH = 2;
    localparam int DATA_DLV_SH   = 8;
    localparam int DATA_TRIG_SH  = 15;

    typedef struct packed {
        logic [15:0] dest;
        logic        masked;
        logic        level;
        logic        rflag;
        logic        dmode;
        logic [2:0]  dlv;
        logic [7:0]  vec;
    } rte_fields_t;

    typedef enum logic [1:0] {
        SVC_IDLE = 2'd0,
        SVC_SCAN = 2'd1,
        SVC_SEND = 2'd2
    } svc_state_t;

    function automatic rte_fields_t rte_decode(input logic [RTE_W-1:0] e);
        rte_fields_t f;
        f.dest   = e[DEST_LO +: 16];
        f.masked = e[MASK_BIT];
        f.level  = e[TRIG_BIT];
        f.rflag  = e[RFLAG_BIT];
        f.dmode  = e[DMODE_BIT];
        f.dlv    = e[DLV_LO +: 3];
        f.vec    = e[VEC_LO +: 8];
        return f;
    endfunction

endpackage

// File: rtl/irq_pin_capture.sv
module irq_pin_capture
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_IN   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_IN-1:0]   irq_in,
    input  logic [NUM_PINS-1:0] pin_level,
    input  logic [NUM_PINS-1:0] pin_masked,
    input  logic [NUM_PINS-1:0] pin_rflag,
    input  logic [NUM_PINS-1:0] svc_clr,
    output logic [NUM_PINS-1:0] pending,
    output logic                start_evt
);

    logic [NUM_PINS-1:0] pin_now;
    logic [NUM_PINS-1:0] pin_q;
    logic [NUM_PINS-1:0] rise;
    logic [NUM_PINS-1:0] edge_take;
    logic [NUM_PINS-1:0] level_arm;

    // Wire-to-pin routing: wire 0 lands on pin 2, pin 0 has no wire.
    for (genvar p = 0; p < NUM_PINS; p++) begin : g_route
        if (p == 0) begin : g_p0
            assign pin_now[p] = 1'b0;
        end else if (p == 2) begin : g_p2
            if (NUM_IN > 2) begin : g_both
                assign pin_now[p] = irq_in[0] | irq_in[2];
            end else begin : g_only0
                assign pin_now[p] = irq_in[0];
            end
        end else if (p < NUM_IN) begin : g_direct
            assign pin_now[p] = irq_in[p];
        end else begin : g_none
            assign pin_now[p] = 1'b0;
        end
    end

    assign rise      = pin_now & ~pin_q;
    assign edge_take = rise & ~pin_level & ~pin_masked;
    assign level_arm = rise & pin_level & ~pin_rflag;
    assign start_evt = |(edge_take | level_arm);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_q   <= '0;
            pending <= '0;
        end else begin
            pin_q <= pin_now;
            for (int p = 0; p < NUM_PINS; p++) begin
                if (pin_level[p]) begin
                    pending[p] <= pin_now[p];
                end else if (edge_take[p]) begin
                    pending[p] <= 1'b1;
                end else if (svc_clr[p]) begin
                    pending[p] <= 1'b0;
                end
            end
        end
    end

    // R6: only a pending pin is ever cleared by the scanner, one at a time
    a_r6_clear_only_pending: assert property (@(posedge clk) disable iff (!rst_n)
        (svc_clr != '0) |-> ($onehot0(svc_clr) && ((svc_clr & ~pending) == '0)));

endmodule

// File: rtl/irq_msg_format.sv
module irq_msg_format
    import irq_svc_pkg::*;
(
    input  rte_fields_t fld,
    output logic [31:0] addr,
    output logic [31:0] data
);

    always_comb begin
        addr = MSG_BASE
             | ({16'd0, fld.dest} << ADDR_DEST_SH)
             | ({31'd0, fld.dmode} << ADDR_DMODE_SH);
        data = {24'd0, fld.vec}
             | ({29'd0, fld.dlv} << DATA_DLV_SH)
             | ({31'd0, fld.level} << DATA_TRIG_SH);
    end

endmodule

// File: rtl/irq_scan_fsm.sv
module irq_scan_fsm
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                kick,
    input  logic                sel_pending,
    input  rte_fields_t         sel_fld,
    input  logic [31:0]         sel_addr,
    input  logic [31:0]         sel_data,
    input  logic                msg_ready,
    output logic [IDX_W-1:0]    scan_idx,
    output logic [NUM_PINS-1:0] svc_clr,
    output logic [NUM_PINS-1:0] rirr_set,
    output logic                msg_valid,
    output logic [31:0]         msg_addr,
    output logic [31:0]         msg_data
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_PINS - 1);

    svc_state_t       state_q, state_d;
    logic [IDX_W-1:0] idx_q, idx_d;
    logic             req_q, req_d;
    logic             load;
    logic             serve;
    logic             want_next;

    assign serve    = sel_pending & ~sel_fld.masked;
    assign scan_idx = idx_q;

    // Next-state process
    always_comb begin
        state_d   = state_q;
        idx_d     = idx_q;
        req_d     = req_q | kick;
        load      = 1'b0;
        want_next = 1'b0;
        unique case (state_q)
            SVC_IDLE: begin
                if (req_q || kick) begin
                    state_d = SVC_SCAN;
                    idx_d   = '0;
                    req_d   = 1'b0;
                end
            end
            SVC_SCAN: begin
                if (serve && (!sel_fld.level || !sel_fld.rflag)) begin
                    load    = 1'b1;
                    state_d = SVC_SEND;
                end else begin
                    want_next = 1'b1;
                end
            end
            SVC_SEND: begin
                if (msg_ready) begin
                    want_next = 1'b1;
                end
            end
            default: begin
                state_d = SVC_IDLE;
            end
        endcase
        if (want_next) begin
            if (idx_q == LAST_IDX) begin
                if (req_q || kick) begin
                    state_d = SVC_SCAN;
                    idx_d   = '0;
                    req_d   = 1'b0;
                end else begin
                    state_d = SVC_IDLE;
                end
            end else begin
                state_d = SVC_SCAN;
                idx_d   = idx_q + 1'b1;
            end
        end
    end

    // State register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= SVC_IDLE;
            idx_q    <= '0;
            req_q    <= 1'b0;
            msg_addr <= '0;
            msg_data <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            req_q   <= req_d;
            if (load) begin
                msg_addr <= sel_addr;
                msg_data <= sel_data;
            end
        end
    end

    // Output process
    always_comb begin
        svc_clr   = '0;
        rirr_set  = '0;
        msg_valid = (state_q == SVC_SEND);
        if (state_q == SVC_SCAN && serve) begin
            if (sel_fld.level) begin
                rirr_set[idx_q] = 1'b1;
            end else begin
                svc_clr[idx_q] = 1'b1;
            end
        end
    end

    // R11: an offered message is held unchanged until accepted
    a_r11_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

    // R4: flag strobe goes to at most one pin per cycle
    a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rirr_set));

    // R10: every offered address carries the fixed base and clear low bits
    a_r10_addr_base: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid |-> (msg_addr[31:20] == MSG_BASE[31:20] && msg_addr[1:0] == 2'b00));

endmodule

// File: rtl/irq_msg_service.sv
module irq_msg_service
    import irq_svc_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_IN   = 32,
    localparam int IDX_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_IN-1:0]         irq_in,
    input  logic [NUM_PINS*RTE_W-1:0] rte_flat,
    input  logic                      tbl_wr,
    input  logic                      rirr_clr,
    output logic [NUM_PINS-1:0]       rirr_set,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [31:0]               msg_addr,
    output logic [31:0]               msg_data
);

    rte_fields_t         fld [NUM_PINS];
    logic [NUM_PINS-1:0] pin_level;
    logic [NUM_PINS-1:0] pin_masked;
    logic [NUM_PINS-1:0] pin_rflag;
    logic [NUM_PINS-1:0] pending;
    logic [NUM_PINS-1:0] svc_clr;
    logic                start_evt;
    logic                kick;
    logic [IDX_W-1:0]    scan_idx;
    rte_fields_t         sel_fld;
    logic                sel_pending;
    logic [31:0]         sel_addr;
    logic [31:0]         sel_data;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_decode
        assign fld[p]        = rte_decode(rte_flat[p*RTE_W +: RTE_W]);
        assign pin_level[p]  = fld[p].level;
        assign pin_masked[p] = fld[p].masked;
        assign pin_rflag[p]  = fld[p].rflag;
    end

    assign sel_fld     = fld[scan_idx];
    assign sel_pending = pending[scan_idx];
    assign kick        = start_evt | tbl_wr | rirr_clr;

    irq_pin_capture #(
        .NUM_PINS (NUM_PINS),
        .NUM_IN   (NUM_IN)
    ) u_capture (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .pin_level  (pin_level),
        .pin_masked (pin_masked),
        .pin_rflag  (pin_rflag),
        .svc_clr    (svc_clr),
        .pending    (pending),
        .start_evt  (start_evt)
    );

    irq_msg_format u_format (
        .fld  (sel_fld),
        .addr (sel_addr),
        .data (sel_data)
    );

    irq_scan_fsm #(
        .NUM_PINS (NUM_PINS)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .kick        (kick),
        .sel_pending (sel_pending),
        .sel_fld     (sel_fld),
        .sel_addr    (sel_addr),
        .sel_data    (sel_data),
        .msg_ready   (msg_ready),
        .scan_idx    (scan_idx),
        .svc_clr     (svc_clr),
        .rirr_set    (rirr_set),
        .msg_valid   (msg_valid),
        .msg_addr    (msg_addr),
        .msg_data    (msg_data)
    );

    // R3: the remote flag is only ever requested for level pins
    a_r3_strobe_level_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rirr_set & ~pin_level) == '0);

    // R8: masked pins are neither cleared nor flagged by the scanner
    a_r8_masked_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        ((rirr_set | svc_clr) & pin_masked) == '0);

endmodule

// File: tb/irq_msg_service_bench.sv
module irq_msg_service_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 24;
    localparam int NI = 32;
    localparam int SETTLE = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NI-1:0]     irq_in = '0;
    logic [NP*64-1:0]  rte_flat;
    logic              tbl_wr = 1'b0;
    logic              rirr_clr = 1'b0;
    logic [NP-1:0]     rirr_set;
    logic              msg_valid;
    logic              msg_ready = 1'b1;
    logic [31:0]       msg_addr;
    logic [31:0]       msg_data;

    logic [63:0]       rte [NP];
    logic [NP-1:0]     rflag_mdl = '0;
    logic [NP-1:0]     clr_mask = '0;
    logic [NP-1:0]     rs_q = '0;

    int checks = 0;
    int failures = 0;
    int n_msg = 0;
    int n_rirr = 0;
    int cyc = 0;
    bit done = 1'b0;
    logic [31:0] log_addr [16];
    logic [31:0] log_data [16];

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_msg_service #(.NUM_PINS(NP), .NUM_IN(NI)) u_irq_msg_service (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .rte_flat(rte_flat),
        .tbl_wr(tbl_wr), .rirr_clr(rirr_clr), .rirr_set(rirr_set),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_addr(msg_addr), .msg_data(msg_data)
    );

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            rte_flat[i*64 +: 64] = rte[i];
            rte_flat[i*64 + 14]  = rflag_mdl[i];
        end
    end

    // Register-block model of the remote flags
    always @(posedge clk) rflag_mdl <= (rflag_mdl & ~clr_mask) | rs_q;

    // Observation at the falling edge
    always @(negedge clk) begin
        rs_q = rirr_set;
        n_rirr += $countones(rirr_set);
        if (msg_valid && msg_ready) begin
            if (n_msg < 16) begin
                log_addr[n_msg] = msg_addr;
                log_data[n_msg] = msg_data;
            end
            n_msg++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            failures++;
            $display("FAIL watchdog act=%0d exp=<20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    function automatic logic [63:0] mk(input logic [15:0] dest, input logic msk,
        input logic lvl, input logic dm, input logic [2:0] dlv, input logic [7:0] vec);
        logic [63:0] e = '0;
        e[63:48] = dest; e[16] = msk; e[15] = lvl; e[11] = dm; e[10:8] = dlv; e[7:0] = vec;
        return e;
    endfunction

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    task automatic clr_log();
        @(negedge clk);
        n_msg = 0;
        n_rirr = 0;
        step(1);
    endtask

    task automatic pulse_wr();
        tbl_wr = 1'b1; step(1); tbl_wr = 1'b0;
    endtask

    task automatic flag_clear(input int p);
        clr_mask[p] = 1'b1; rirr_clr = 1'b1; step(1);
        clr_mask = '0; rirr_clr = 1'b0;
    endtask

    task automatic settle();
        step(SETTLE);
        @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(msg_valid == 1'b0, "R1", "valid in reset", 32'(msg_valid), 0);
        chk(rirr_set == '0, "R1", "strobe in reset", 32'(rirr_set), 0);
        rst_n = 1'b1;
        settle();
        chk(n_msg == 0 && !msg_valid, "R1", "idle after reset", n_msg, 0);
    endtask

    task automatic t_level();
        rte[5] = mk(16'h1234, 0, 1, 1, 3'd1, 8'h41);
        pulse_wr(); settle(); clr_log();
        irq_in[5] = 1'b1;
        settle();
        chk(n_msg == 1, "R3", "level msg count", n_msg, 1);
        chk(n_rirr == 1, "R3", "level strobe count", n_rirr, 1);
        chk(log_addr[0] == 32'hFEE12344, "R10", "level addr", log_addr[0], 32'hFEE12344);
        chk(log_data[0] == 32'h00008141, "R10", "level data", log_data[0], 32'h00008141);
        clr_log(); pulse_wr(); settle();
        chk(n_msg == 0, "R4", "coalesced msg", n_msg, 0);
        chk(n_rirr == 1, "R4", "coalesced strobe", n_rirr, 1);
        clr_log(); flag_clear(5); settle();
        chk(n_msg == 1, "R12", "resend after clear", n_msg, 1);
        clr_log(); irq_in[5] = 1'b0; step(2); flag_clear(5); settle();
        chk(n_msg == 0, "R5", "low input not sent", n_msg, 0);
        chk(n_rirr == 0, "R5", "low input no strobe", n_rirr, 0);
    endtask

    task automatic t_edge();
        rte[7] = mk(16'h00FF, 0, 0, 0, 3'd0, 8'h30);
        pulse_wr(); settle(); clr_log();
        irq_in[7] = 1'b1; step(1); irq_in[7] = 1'b0;
        settle();
        chk(n_msg == 1, "R6", "edge msg count", n_msg, 1);
        chk(n_rirr == 0, "R6", "edge no strobe", n_rirr, 0);
        chk(log_addr[0] == 32'hFEE00FF0, "R10", "edge addr", log_addr[0], 32'hFEE00FF0);
        chk(log_data[0] == 32'h00000030, "R10", "edge data", log_data[0], 32'h00000030);
        clr_log(); pulse_wr(); settle();
        chk(n_msg == 0, "R6", "edge not resent", n_msg, 0);
    endtask

    task automatic t_edge_masked();
        rte[8] = mk(16'h0000, 1, 0, 0, 3'd0, 8'h31);
        pulse_wr(); settle(); clr_log();
        irq_in[8] = 1'b1; step(1); irq_in[8] = 1'b0;
        settle();
        chk(n_msg == 0, "R7", "masked edge", n_msg, 0);
        rte[8] = mk(16'h0000, 0, 0, 0, 3'd0, 8'h31);
        pulse_wr(); settle();
        chk(n_msg == 0, "R7", "masked edge after unmask", n_msg, 0);
    endtask

    task automatic t_level_masked();
        rte[9] = mk(16'h0002, 1, 1, 0, 3'd2, 8'h50);
        pulse_wr(); settle(); clr_log();
        irq_in[9] = 1'b1;
        step(2); pulse_wr(); settle();
        chk(n_msg == 0, "R8", "masked level held", n_msg, 0);
        chk(n_rirr == 0, "R8", "masked level no strobe", n_rirr, 0);
        rte[9] = mk(16'h0002, 0, 1, 0, 3'd2, 8'h50);
        pulse_wr(); settle();
        chk(n_msg == 1, "R8", "unmasked level sent", n_msg, 1);
        chk(log_data[0] == 32'h00008250 && log_addr[0] == 32'hFEE00020, "R10",
            "unmasked level data", log_data[0], 32'h00008250);
        irq_in[9] = 1'b0;
        rte[9] = mk(16'h0002, 1, 1, 0, 3'd2, 8'h50);
        step(2); flag_clear(9); settle();
    endtask

    task automatic t_remap();
        rte[2] = mk(16'h0000, 0, 0, 0, 3'd0, 8'h22);
        rte[0] = mk(16'h0000, 0, 0, 0, 3'd0, 8'h10);
        pulse_wr(); settle(); clr_log();
        irq_in[0] = 1'b1; step(1); irq_in[0] = 1'b0;
        settle();
        chk(n_msg == 1, "R2", "wire 0 count", n_msg, 1);
        chk(log_data[0] == 32'h00000022, "R2", "wire 0 lands on pin 2", log_data[0], 32'h22);
        clr_log();
        irq_in[30] = 1'b1; step(1); irq_in[30] = 1'b0;
        settle();
        chk(n_msg == 0, "R2", "wire beyond pins", n_msg, 0);
    endtask

    task automatic t_order_stall();
        logic [31:0] held;
        rte[3]  = mk(16'h0000, 0, 0, 0, 3'd0, 8'h03);
        rte[11] = mk(16'h0000, 0, 0, 0, 3'd0, 8'h0B);
        rte[20] = mk(16'h0000, 0, 0, 0, 3'd0, 8'h14);
        pulse_wr(); settle(); clr_log();
        msg_ready = 1'b0;
        irq_in[20] = 1'b1; irq_in[11] = 1'b1; irq_in[3] = 1'b1;
        step(1);
        irq_in[20] = 1'b0; irq_in[11] = 1'b0; irq_in[3] = 1'b0;
        settle();
        held = msg_data;
        chk(msg_valid == 1'b1, "R11", "valid under stall", 32'(msg_valid), 1);
        chk(held == 32'h00000003, "R9", "first offered", held, 32'h3);
        step(5); @(negedge clk);
        chk(msg_valid == 1'b1 && msg_data == held, "R11", "held data", msg_data, held);
        chk(n_msg == 0, "R11", "nothing accepted", n_msg, 0);
        msg_ready = 1'b1;
        settle();
        chk(n_msg == 3, "R9", "order count", n_msg, 3);
        chk(log_data[0] == 32'h03, "R9", "order slot 0", log_data[0], 32'h03);
        chk(log_data[1] == 32'h0B, "R9", "order slot 1", log_data[1], 32'h0B);
        chk(log_data[2] == 32'h14, "R9", "order slot 2", log_data[2], 32'h14);
    endtask

    initial begin
        for (int i = 0; i < NP; i++) rte[i] = mk(16'h0000, 1, 0, 0, 3'd0, 8'h00);
        step(3);
        t_reset();
        t_level();
        t_edge();
        t_edge_masked();
        t_level_masked();
        t_remap();
        t_order_stall();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule